// File: doc/BRIEF.md
# Memory Boundary-Scan Test Port

This block is the boundary-scan access port of a memory device. A 16-state controller is advanced on rising TCK edges by TMS. It selects one of three serial paths between TDI and TDO: a one-bit bypass cell, a 32-bit identification register loaded from a constant, or a boundary register with one cell per pad. The instruction that picks the path is held in a 3-bit register. The pad values that the boundary register captures arrive on an input vector. The outputs toward the memory core are four control flags and a per-pad drive vector.

The instruction set has a few quirks. There is no preload step, so passing through Update-DR under SAMPLE changes nothing. The external-test instruction only arms the pad drivers. The actual transfer of boundary-register contents to the pads happens on a rising edge of the memory's main clock `ck`, not on TCK. Two reserved codes and one private code act as plain bypass, and a separate instruction floats every memory output.

Top module: `mem_scan_port`

## Requirements
- R1: The instruction register is 3 bits wide and is shifted least significant bit first. Capture-IR loads binary 001, so the first bit out is 1 and the next two are 0. The decodes are: 000 external test, 001 identification, 010 float outputs, 100 sample, 111 bypass. Codes 011, 101 and 110 behave as bypass.
- R2: After asynchronous `trst_n` low, the controller is in Test-Logic-Reset and the identification instruction is active. The same holds after five consecutive rising TCK edges with TMS high, from any state.
- R3: Under identification, Capture-DR loads the `ID_VALUE` constant, and Shift-DR shifts it out least significant bit first.
- R4: Under float outputs (010), `core_hiz` is 1 and the other three core flags are 0. The boundary register is the serial path.
- R5: Under sample (100), Capture-DR loads `pad_in` into the boundary register, which then shifts with TDI entering the top cell and cell 0 leaving first. Update-DR has no effect, and `pad_out` keeps its value across `ck` edges.
- R6: Under external test (000), `core_ctl_override`, `core_drv_enable` and `core_scan_select` are 1, `core_hiz` is 0, and the boundary register is the serial path.
- R7: While external test is active, each rising `ck` edge copies boundary cell i to `pad_out[i]`. Further edges leave `pad_out` unchanged while the register is unchanged. Under any other instruction, `pad_out` holds its value.
- R8: Under 011, 101, 110 and 111, the serial path is a single cell that captures 0, and all four core flags are 0.
- R9: `tdo` changes only on falling TCK edges. `tdo_en` is 1 exactly while the controller is in Shift-DR or Shift-IR.
- R10: Asserting `trst_n` low clears all four core flags, `tdo_en` and `pad_out` without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| ck | input | 1 | Memory main clock, moves scan data to the pads during external test |
| pad_in | input | BSR_LEN | Present pad values for boundary capture |
| tdo | output | 1 | Serial test data out |
| tdo_en | output | 1 | High when tdo is actively driven |
| core_hiz | output | 1 | Forces all memory outputs to high impedance |
| core_ctl_override | output | 1 | Overrides the memory control inputs |
| core_drv_enable | output | 1 | Enables the data output drivers |
| core_scan_select | output | 1 | Selects scan data as the pad output source |
| pad_out | output | BSR_LEN | Scan data delivered to the pad drivers |

## Verification
Two events can land in the same stretch of time. One is a `ck` rising edge that moves boundary data to the pads. The other is the TCK shift that is still changing that boundary data. The bench provokes this by pulsing `ck` between every pair of shift edges while an external-test scan is in progress. After each pulse, it compares `pad_out` with a bench model of the partially shifted register. It then confirms that one final pulse after the scan delivers exactly the scanned pattern, and that a second pulse changes nothing.

// File: rtl/scan_port_pkg.sv
// Package: shared encodings for the memory boundary-scan port.
// Holds controller states, instruction codes, serial path choices and the
// instruction decode. Assumes a 3-bit instruction register.
package scan_port_pkg;

    localparam int IR_W = 3;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [3:0] {
        ST_RESET  = 4'd0,
        ST_IDLE   = 4'd1,
        ST_DR_SEL = 4'd2,
        ST_DR_CAP = 4'd3,
        ST_DR_SHF = 4'd4,
        ST_DR_EX1 = 4'd5,
        ST_DR_PAU = 4'd6,
        ST_DR_EX2 = 4'd7,
        ST_DR_UPD = 4'd8,
        ST_IR_SEL = 4'd9,
        ST_IR_CAP = 4'd10,
        ST_IR_SHF = 4'd11,
        ST_IR_EX1 = 4'd12,
        ST_IR_PAU = 4'd13,
        ST_IR_EX2 = 4'd14,
        ST_IR_UPD = 4'd15
    } tap_state_e;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST = 3'b000,
        OP_IDENT  = 3'b001,
        OP_FLOAT  = 3'b010,
        OP_RSV_A  = 3'b011,
        OP_SAMPLE = 3'b100,
        OP_PRIV   = 3'b101,
        OP_RSV_B  = 3'b110,
        OP_BYPASS = 3'b111
    } op_e;

    typedef enum logic [1:0] {
        PATH_BYP = 2'd0,
        PATH_ID  = 2'd1,
        PATH_BSR = 2'd2
    } path_e;

    typedef struct packed {
        logic  hiz;
        logic  ctl_ovr;
        logic  drv_en;
        logic  scan_sel;
        path_e path;
    } op_ctrl_t;

    // Maps an instruction to its serial path and its core control flags.
    function automatic op_ctrl_t decode_op(input op_e op);
        op_ctrl_t c;
        c = '{hiz: 1'b0, ctl_ovr: 1'b0, drv_en: 1'b0, scan_sel: 1'b0, path: PATH_BYP};
        case (op)
            OP_EXTEST: begin
                c.ctl_ovr  = 1'b1;
                c.drv_en   = 1'b1;
                c.scan_sel = 1'b1;
                c.path     = PATH_BSR;
            end
            OP_IDENT:  c.path = PATH_ID;
            OP_FLOAT: begin
                c.hiz  = 1'b1;
                c.path = PATH_BSR;
            end
            OP_SAMPLE: c.path = PATH_BSR;
            default:   c.path = PATH_BYP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
// Module: the 16-state test controller.
// Advances on rising tck according to tms. Assumes trst_n is an
// asynchronous active-low reset that forces Test-Logic-Reset.
module scan_tap_fsm
    import scan_port_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;

    // Next-state selection from the present state and tms.
    always_comb begin
        case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_DR_SEL : ST_IDLE;
            ST_DR_SEL: nxt = tms ? ST_IR_SEL : ST_DR_CAP;
            ST_DR_CAP: nxt = tms ? ST_DR_EX1 : ST_DR_SHF;
            ST_DR_SHF: nxt = tms ? ST_DR_EX1 : ST_DR_SHF;
            ST_DR_EX1: nxt = tms ? ST_DR_UPD : ST_DR_PAU;
            ST_DR_PAU: nxt = tms ? ST_DR_EX2 : ST_DR_PAU;
            ST_DR_EX2: nxt = tms ? ST_DR_UPD : ST_DR_SHF;
            ST_DR_UPD: nxt = tms ? ST_DR_SEL : ST_IDLE;
            ST_IR_SEL: nxt = tms ? ST_RESET  : ST_IR_CAP;
            ST_IR_CAP: nxt = tms ? ST_IR_EX1 : ST_IR_SHF;
            ST_IR_SHF: nxt = tms ? ST_IR_EX1 : ST_IR_SHF;
            ST_IR_EX1: nxt = tms ? ST_IR_UPD : ST_IR_PAU;
            ST_IR_PAU: nxt = tms ? ST_IR_EX2 : ST_IR_PAU;
            ST_IR_EX2: nxt = tms ? ST_IR_UPD : ST_IR_SHF;
            ST_IR_UPD: nxt = tms ? ST_DR_SEL : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    // State register with asynchronous test reset.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

endmodule

// File: rtl/scan_instr_reg.sv
// Module: instruction shift stage and held instruction.
// Captures the fixed pattern in Capture-IR and shifts LSB first in Shift-IR.
// Applies the shifted value in Update-IR. Test-Logic-Reset and trst_n both
// restore the identification instruction.
module scan_instr_reg
    import scan_port_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e state,
    input  logic       tdi,
    output op_e        op,
    output logic       ir_lsb
);

    logic [IR_W-1:0] sr;

    // Shift stage: capture the fixed pattern, then shift toward bit 0.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr <= IR_CAPTURE;
        end else begin
            case (state)
                ST_IR_CAP: sr <= IR_CAPTURE;
                ST_IR_SHF: sr <= {tdi, sr[IR_W-1:1]};
                default:   sr <= sr;
            endcase
        end
    end

    // Held instruction: default on reset, new value on update.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                 op <= OP_IDENT;
        else if (state == ST_RESET)  op <= OP_IDENT;
        else if (state == ST_IR_UPD) op <= op_e'(sr);
    end

    assign ir_lsb = sr[0];

endmodule

// File: rtl/scan_data_regs.sv
// Module: the three data paths (bypass, identification, boundary).
// Only the path selected by the instruction captures and shifts.
// There is no parallel update stage: Update-DR leaves every cell alone.
module scan_data_regs
    import scan_port_pkg::*;
#(
    parameter int          BSR_LEN  = 8,
    parameter logic [31:0] ID_VALUE = 32'h2C4E_A5B3
) (
    input  logic               tck,
    input  logic               trst_n,
    input  tap_state_e         state,
    input  path_e              path,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pad_in,
    output logic [BSR_LEN-1:0] bsr_q,
    output logic               dr_lsb
);

    localparam int ID_W = 32;

    logic            byp_q;
    logic [ID_W-1:0] id_q;
    logic            cap_en;
    logic            shf_en;

    assign cap_en = (state == ST_DR_CAP);
    assign shf_en = (state == ST_DR_SHF);

    // Bypass cell: captures 0 and shifts tdi through.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                         byp_q <= 1'b0;
        else if (path == PATH_BYP && cap_en) byp_q <= 1'b0;
        else if (path == PATH_BYP && shf_en) byp_q <= tdi;
    end

    // Identification register: loads the constant and shifts LSB first.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                        id_q <= '0;
        else if (path == PATH_ID && cap_en) id_q <= ID_VALUE;
        else if (path == PATH_ID && shf_en) id_q <= {tdi, id_q[ID_W-1:1]};
    end

    // Boundary cells, one per pad: tdi enters the top cell.
    for (genvar g = 0; g < BSR_LEN; g++) begin : g_cell
        logic src;
        if (g == BSR_LEN - 1) begin : g_top
            assign src = tdi;
        end else begin : g_mid
            assign src = bsr_q[g+1];
        end

        // Capture the pad value or take the neighbour's bit.
        always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)                         bsr_q[g] <= 1'b0;
            else if (path == PATH_BSR && cap_en) bsr_q[g] <= pad_in[g];
            else if (path == PATH_BSR && shf_en) bsr_q[g] <= src;
        end
    end

    // Serial output bit of the selected path.
    always_comb begin
        case (path)
            PATH_ID:  dr_lsb = id_q[0];
            PATH_BSR: dr_lsb = bsr_q[0];
            default:  dr_lsb = byp_q;
        endcase
    end

endmodule

// File: rtl/scan_pin_drive.sv
// Module: pad data stage clocked by the memory main clock.
// While armed, each rising ck copies the boundary cells to the pads.
// Otherwise the pads hold their value. Assumes bsr_q is stable around ck
// edges (tck and ck are not edge-aligned).
module scan_pin_drive #(
    parameter int BSR_LEN = 8
) (
    input  logic               ck,
    input  logic               trst_n,
    input  logic               arm,
    input  logic [BSR_LEN-1:0] bsr_q,
    output logic [BSR_LEN-1:0] pad_out
);

    for (genvar g = 0; g < BSR_LEN; g++) begin : g_pad
        // Per-pad transfer on ck while armed.
        always_ff @(posedge ck or negedge trst_n) begin
            if (!trst_n)  pad_out[g] <= 1'b0;
            else if (arm) pad_out[g] <= bsr_q[g];
        end
    end

endmodule

// File: rtl/mem_scan_port.sv
// Module: top of the memory boundary-scan port.
// Ties together the controller, the instruction register, the data paths
// and the pad stage. Decodes the instruction into core flags. Drives tdo
// on falling tck. Assumes trst_n is asynchronous and active low.
module mem_scan_port
    import scan_port_pkg::*;
#(
    parameter int          BSR_LEN  = 8,
    parameter logic [31:0] ID_VALUE = 32'h2C4E_A5B3
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic               ck,
    input  logic [BSR_LEN-1:0] pad_in,
    output logic               tdo,
    output logic               tdo_en,
    output logic               core_hiz,
    output logic               core_ctl_override,
    output logic               core_drv_enable,
    output logic               core_scan_select,
    output logic [BSR_LEN-1:0] pad_out
);

    tap_state_e         tap_state;
    op_e                ir_op;
    op_ctrl_t           ctrl;
    logic               ir_lsb;
    logic               dr_lsb;
    logic [BSR_LEN-1:0] bsr_q;

    scan_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (tap_state)
    );

    scan_instr_reg u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (tap_state),
        .tdi    (tdi),
        .op     (ir_op),
        .ir_lsb (ir_lsb)
    );

    // Instruction decode into path and core flags.
    always_comb ctrl = decode_op(ir_op);

    scan_data_regs #(
        .BSR_LEN  (BSR_LEN),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (tap_state),
        .path   (ctrl.path),
        .tdi    (tdi),
        .pad_in (pad_in),
        .bsr_q  (bsr_q),
        .dr_lsb (dr_lsb)
    );

    scan_pin_drive #(
        .BSR_LEN (BSR_LEN)
    ) u_pad (
        .ck      (ck),
        .trst_n  (trst_n),
        .arm     (ctrl.scan_sel),
        .bsr_q   (bsr_q),
        .pad_out (pad_out)
    );

    // Serial output and its enable, retimed to falling tck.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (tap_state == ST_DR_SHF) || (tap_state == ST_IR_SHF);
            tdo    <= (tap_state == ST_IR_SHF) ? ir_lsb : dr_lsb;
        end
    end

    assign core_hiz          = ctrl.hiz;
    assign core_ctl_override = ctrl.ctl_ovr;
    assign core_drv_enable   = ctrl.drv_en;
    assign core_scan_select  = ctrl.scan_sel;

endmodule

// File: rtl/scan_port_chk.sv
// Module: property checker bound to mem_scan_port.
// Observes the controller state, the held instruction and the outputs.
// Assumes the same asynchronous active-low trst_n as the design.
module scan_port_chk
    import scan_port_pkg::*;
#(
    parameter int BSR_LEN = 8
) (
    input logic               tck,
    input logic               ck,
    input logic               trst_n,
    input logic               tms,
    input tap_state_e         st,
    input op_e                ir,
    input logic               tdo_en,
    input logic               core_hiz,
    input logic               core_ctl_override,
    input logic               core_drv_enable,
    input logic               core_scan_select,
    input logic [BSR_LEN-1:0] pad_out
);

    logic [2:0] ones;

    // Count consecutive rising tck edges with tms high, saturating at five.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)          ones <= 3'd0;
        else if (!tms)        ones <= 3'd0;
        else if (ones != 3'd5) ones <= ones + 3'd1;
    end

    AST_FIVE_HIGH_RESETS: assert property (@(posedge tck) disable iff (!trst_n)
        (ones == 3'd5) |-> (st == ST_RESET)); // R2

    AST_RESET_LOADS_IDENT: assert property (@(posedge tck) disable iff (!trst_n)
        (st == ST_RESET) |=> (ir == OP_IDENT)); // R2

    AST_ENABLE_IN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en == ((st == ST_DR_SHF) || (st == ST_IR_SHF))); // R9

    AST_BYPASS_NO_FLAGS: assert property (@(posedge tck) disable iff (!trst_n)
        (ir == OP_RSV_A || ir == OP_PRIV || ir == OP_RSV_B || ir == OP_BYPASS)
        |-> !(core_hiz || core_ctl_override || core_drv_enable || core_scan_select)); // R8

    AST_PADS_HOLD_UNARMED: assert property (@(posedge ck) disable iff (!trst_n)
        !core_scan_select |=> $stable(pad_out)); // R7

endmodule

bind mem_scan_port scan_port_chk #(.BSR_LEN(BSR_LEN)) u_chk (
    .tck               (tck),
    .ck                (ck),
    .trst_n            (trst_n),
    .tms               (tms),
    .st                (tap_state),
    .ir                (ir_op),
    .tdo_en            (tdo_en),
    .core_hiz          (core_hiz),
    .core_ctl_override (core_ctl_override),
    .core_drv_enable   (core_drv_enable),
    .core_scan_select  (core_scan_select),
    .pad_out           (pad_out)
);

// File: tb/sim_mem_scan_port.sv
module sim_mem_scan_port;

    localparam int          BSR_LEN = 8;
    localparam logic [31:0] IDV     = 32'h2C4E_A5B3;
    localparam int          ID_LEN  = 32;

    logic tck, trst_n, tms, tdi, ck;
    logic [BSR_LEN-1:0] pad_in, pad_out;
    logic tdo, tdo_en, core_hiz, core_ctl_override, core_drv_enable, core_scan_select;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;
    logic s_tdo, s_en;
    logic [BSR_LEN-1:0] last_pad;

    mem_scan_port #(.BSR_LEN(BSR_LEN), .ID_VALUE(IDV)) u0 (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .ck(ck), .pad_in(pad_in),
        .tdo(tdo), .tdo_en(tdo_en), .core_hiz(core_hiz),
        .core_ctl_override(core_ctl_override), .core_drv_enable(core_drv_enable),
        .core_scan_select(core_scan_select), .pad_out(pad_out)
    );

    initial tck = 1'b0;
    always #10 tck = ~tck;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Sample outputs just after falling tck, then drive the next tms/tdi.
    task automatic step(input logic m, input logic d);
        @(negedge tck);
        #1;
        s_tdo = tdo;
        s_en  = tdo_en;
        tms   = m;
        tdi   = d;
    endtask

    task automatic pulse_ck();
        #1 ck = 1'b1;
        #2 ck = 1'b0;
        #1;
    endtask

    function automatic int path_len(input logic [2:0] c);
        if (c == 3'b000 || c == 3'b010 || c == 3'b100) return BSR_LEN;
        if (c == 3'b001) return ID_LEN;
        return 1;
    endfunction

    function automatic logic [63:0] cap_val(input logic [2:0] c, input logic [BSR_LEN-1:0] p);
        if (path_len(c) == BSR_LEN) return 64'(p);
        if (c == 3'b001) return 64'(IDV);
        return 64'd0;
    endfunction

    // Expected flags {hiz, override, drive enable, scan select}.
    function automatic logic [3:0] exp_flags(input logic [2:0] c);
        if (c == 3'b000) return 4'b0111;
        if (c == 3'b010) return 4'b1000;
        return 4'b0000;
    endfunction

    function automatic logic [63:0] exp_stream(input int n, input int l, input logic [63:0] cap, input logic [63:0] din);
        logic [63:0] o = '0;
        for (int i = 0; i < n; i++) o[i] = (i < l) ? cap[i] : din[i-l];
        return o;
    endfunction

    // Boundary register contents after k shifts.
    function automatic logic [63:0] bsr_after(input int k, input logic [63:0] cap, input logic [63:0] din);
        logic [63:0] m = (k == 0) ? 64'd0 : ((64'd1 << k) - 64'd1);
        logic [63:0] lm = (64'd1 << BSR_LEN) - 64'd1;
        return ((cap >> k) | ((din & m) << (BSR_LEN - k))) & lm;
    endfunction

    task automatic load_ir(input logic [2:0] code);
        logic [2:0] cap;
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 3; i++) begin
            step(i == 2, code[i]);
            cap[i] = s_tdo;
            check(s_en == 1'b1, "R9 tdo_en in Shift-IR", 64'(s_en), 64'd1);
        end
        check(cap == 3'b001, "R1 Capture-IR pattern", 64'(cap), 64'd1);
        step(1, 0); step(0, 0); step(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i]);
            dout[i] = s_tdo;
        end
        step(1, 0); step(0, 0); step(0, 0);
        check(s_en == 1'b0, "R9 tdo_en off in Run-Test/Idle", 64'(s_en), 64'd0);
    endtask

    function automatic logic [3:0] flags();
        return {core_hiz, core_ctl_override, core_drv_enable, core_scan_select};
    endfunction

    initial begin
        repeat (150000) @(posedge tck);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] dout, din, exp, capv;
        logic [2:0]  code;
        int          n, l;
        tms = 1'b1; tdi = 1'b0; ck = 1'b0; pad_in = '0; trst_n = 1'b0;
        void'($urandom(32'h5EED));
        #25;
        // R10 R2: reset state.
        check(flags() == 4'b0000, "R10 flags in reset", 64'(flags()), 64'd0);
        check(tdo_en == 1'b0, "R10 tdo_en in reset", 64'(tdo_en), 64'd0);
        check(pad_out == '0, "R10 pad_out in reset", 64'(pad_out), 64'd0);
        @(negedge tck); #1 trst_n = 1'b1;
        step(0, 0);
        // R3 R2: identification is the default path.
        scan_dr(ID_LEN, 64'h0, dout);
        check(dout[31:0] == IDV, "R2 R3 default ident", dout, 64'(IDV));
        last_pad = '0;

        // Randomised instruction/data rounds.
        for (int r = 0; r < 24; r++) begin
            code = 3'($urandom % 8);
            if (r < 8) code = 3'(r);
            load_ir(code);
            check(flags() == exp_flags(code), "R4 R6 R8 core flags", 64'(flags()), 64'(exp_flags(code)));
            pad_in = BSR_LEN'($urandom);
            din    = {$urandom, $urandom};
            l      = path_len(code);
            n      = (l == 1) ? 6 : l;
            capv   = cap_val(code, pad_in);
            scan_dr(n, din, dout);
            exp = exp_stream(n, l, capv, din);
            if (code == 3'b100)
                check(dout == exp, "R5 sample capture/shift", dout, exp);
            else if (code == 3'b001)
                check(dout == exp, "R3 ident shift", dout, exp);
            else if (l == 1)
                check(dout == exp, "R8 bypass cell", dout, exp);
            else
                check(dout == exp, "R4 R6 boundary path", dout, exp);
            pulse_ck();
            if (code == 3'b000) begin
                last_pad = din[BSR_LEN-1:0];
                check(pad_out == last_pad, "R7 ck transfer", 64'(pad_out), 64'(last_pad));
                pulse_ck();
                check(pad_out == last_pad, "R7 repeated ck", 64'(pad_out), 64'(last_pad));
            end else begin
                check(pad_out == last_pad, "R7 pads held", 64'(pad_out), 64'(last_pad));
            end
        end

        // R7: ck edges interleaved with external-test shifting.
        load_ir(3'b000);
        pad_in = BSR_LEN'($urandom);
        capv   = 64'(pad_in);
        din    = 64'(BSR_LEN'($urandom));
        step(1, 0); step(0, 0); step(0, 0);
        for (int k = 0; k < BSR_LEN; k++) begin
            step(k == BSR_LEN - 1, din[k]);
            @(posedge tck);
            #3 ck = 1'b1;
            #2 ck = 1'b0;
            #1;
            exp = bsr_after(k + 1, capv, din);
            check(64'(pad_out) == exp, "R7 ck during shift", 64'(pad_out), exp);
        end
        step(1, 0); step(0, 0); step(0, 0);
        pulse_ck();
        last_pad = din[BSR_LEN-1:0];
        check(pad_out == last_pad, "R7 final ck after scan", 64'(pad_out), 64'(last_pad));

        // R5: sample through Update-DR leaves pads untouched.
        load_ir(3'b100);
        pad_in = ~last_pad;
        scan_dr(BSR_LEN, 64'hA5, dout);
        check(dout[BSR_LEN-1:0] == pad_in, "R5 sample capture", dout, 64'(pad_in));
        pulse_ck();
        check(pad_out == last_pad, "R5 no update effect", 64'(pad_out), 64'(last_pad));

        // R9: tdo changes only on falling tck.
        load_ir(3'b111);
        step(1, 0); step(0, 0); step(0, 0);
        step(0, 1);
        check(s_tdo == 1'b0 && s_en == 1'b1, "R9 bypass first bit", 64'({s_en, s_tdo}), 64'h2);
        @(posedge tck); #2;
        check(tdo == 1'b0, "R9 tdo steady after rising", 64'(tdo), 64'd0);
        @(negedge tck); #1;
        check(tdo == 1'b1, "R9 tdo after falling", 64'(tdo), 64'd1);
        // R2: five tms-high edges from Shift-DR.
        step(1, 0); step(1, 0); step(1, 0); step(1, 0); step(1, 0);
        step(0, 0); step(0, 0);
        check(flags() == 4'b0000, "R2 flags after tms reset", 64'(flags()), 64'd0);
        scan_dr(ID_LEN, 64'h0, dout);
        check(dout[31:0] == IDV, "R2 ident after tms reset", dout, 64'(IDV));

        // R10: asynchronous reset clears an armed external test.
        load_ir(3'b000);
        check(flags() == 4'b0111, "R6 armed", 64'(flags()), 64'h7);
        #3 trst_n = 1'b0;
        #2;
        check(flags() == 4'b0000, "R10 flags cleared", 64'(flags()), 64'd0);
        check(pad_out == '0, "R10 pad_out cleared", 64'(pad_out), 64'd0);
        check(tdo_en == 1'b0, "R10 tdo_en cleared", 64'(tdo_en), 64'd0);
        @(negedge tck); #1 trst_n = 1'b1;
        step(0, 0);
        scan_dr(ID_LEN, 64'h0, dout);
        check(dout[31:0] == IDV, "R2 ident after trst_n", dout, 64'(IDV));

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule